// File: doc/BRIEF.md
# Virtualization-Aware Exception Vector Router

This block decides where a processor core fetches next when it takes an exception or an interrupt. The core runs a hypervisor (host, root mode) next to guest software (non-root mode). Each cycle the block samples these inputs:

- seven pending event lines;
- the current privilege level and the guest/host mode bit;
- the decode flags of the instruction in flight: valid, privileged and sensitive;
- two vector base values, one for the guest's kernel/user table and one for the hypervisor table;
- a high-vector select.

When at least one source is active, the block picks the winner by fixed priority. It then decides which of the two tables services the winner and registers the result. One cycle after the inputs are sampled it raises a one-cycle taken strobe. Together with the strobe it gives the target fetch address, the new privilege level and the new guest/host mode.

Three trap sources are built inside the block:

- A privileged instruction executed at user level traps as an undefined instruction.
- In guest mode, any instruction flagged sensitive traps to the hypervisor, whatever the current level.
- In host mode the sensitive flag is ignored.

A 3-bit cause and a "taken to hypervisor" flag are latched on every exception. They hold between exceptions so that they can feed a syndrome register.

Top module: `exc_vec_router`

## Requirements
- R1: After asynchronous reset, take_o is 0, cause_o is 0, to_hyp_o is 0, new_pl_o is 2 (hypervisor level) and new_guest_o is 0.
- R2: If a trap source is active in the cycle sampled at a rising edge, take_o is 1 for the cycle after that edge. If no source is active, take_o is 0. Each sampled cycle gives at most one strobe.
- R3: The target is base + 4*slot. The slots are: reset 0, undefined 1, supervisor call 2, prefetch abort 3, data abort 4, IRQ 6, FIQ 7. A sensitive trap uses slot 1. Slot 5 (offset 0x14) is never produced.
- R4: With hi_vec_i = 1 the base is 0xFFFF0000 for either table. With hi_vec_i = 0 the base is hyp_vbar_i for hypervisor routing and gst_vbar_i for guest routing.
- R5: When several sources are active at once, exactly one is serviced. The priority order is reset, data abort, FIQ, IRQ, prefetch abort, guest sensitive trap, undefined (event or privileged trap), supervisor call.
- R6: A valid instruction with insn_priv_i = 1 traps with cause 1 when cur_pl_i = 0 (user). It does not trap at levels 1 or 2.
- R7: In host mode (guest_i = 0):
  - every exception uses the hypervisor table and gives to_hyp_o = 1 and new_guest_o = 0;
  - new_pl_o is 2 when taken from level 2 and 1 otherwise;
  - insn_sens_i has no effect.
- R8: In guest mode, a valid sensitive instruction traps to the hypervisor table at slot 1. This holds at any level and whether or not the instruction is privileged. It gives cause 5, new_pl_o = 2, new_guest_o = 0 and to_hyp_o = 1.
- R9: In guest mode, a supervisor call goes to the guest table at slot 2, with new_pl_o = 1, new_guest_o = 1 and to_hyp_o = 0.
- R10: In guest mode, IRQ and FIQ go to the hypervisor table, with new_pl_o = 2, new_guest_o = 0 and to_hyp_o = 1.
- R11: In guest mode, undefined instruction (event or privileged trap), prefetch abort and data abort go to the guest table, with new_pl_o = 1 and new_guest_o = 1.
- R12: A reset event always uses the hypervisor table at slot 0, with new_pl_o = 2, new_guest_o = 0, to_hyp_o = 1 and cause 0.
- R13: cause_o and to_hyp_o change only in a cycle where take_o is 1, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_reset_i | input | 1 | Reset event pending |
| ev_undef_i | input | 1 | Undefined instruction event pending |
| ev_svc_i | input | 1 | Supervisor call pending |
| ev_pabt_i | input | 1 | Prefetch abort pending |
| ev_dabt_i | input | 1 | Data abort pending |
| ev_irq_i | input | 1 | Normal interrupt pending |
| ev_fiq_i | input | 1 | Fast interrupt pending |
| insn_valid_i | input | 1 | Decode flags below are valid |
| insn_priv_i | input | 1 | Instruction is privileged |
| insn_sens_i | input | 1 | Instruction is sensitive |
| cur_pl_i | input | 2 | Current level: 0 user, 1 kernel, 2 hypervisor |
| guest_i | input | 1 | 1 = guest (non-root) mode |
| hi_vec_i | input | 1 | Select high vector base 0xFFFF0000 |
| gst_vbar_i | input | 32 | Guest table base |
| hyp_vbar_i | input | 32 | Hypervisor table base |
| take_o | output | 1 | One-cycle exception taken strobe |
| tgt_pc_o | output | 32 | Vector fetch address |
| new_pl_o | output | 2 | Privilege level after the exception |
| new_guest_o | output | 1 | Guest mode after the exception |
| cause_o | output | 3 | Latched cause code (slot number, 5 = sensitive trap) |
| to_hyp_o | output | 1 | Latched: last exception went to the hypervisor table |

## Verification
The hardest situation to reach is a guest-mode cycle where a sensitive instruction competes with other sources. Examples are a privileged and sensitive instruction at user level, or a sensitive instruction together with a guest-routed abort. Here the winner decides both the table and whether the core leaves guest mode. The stimulus table drives these overlaps directly: sensitive with privileged, sensitive with a supervisor call, and sensitive below an abort. It also steps through each priority pair in turn. A separate sweep shows that slot 5 never appears, and idle cycles after a trap show that the syndrome fields hold.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

  localparam int NUM_SRC = 8;
  localparam int SRC_W   = $clog2(NUM_SRC);

  typedef enum logic [1:0] {
    PL_USR = 2'd0,
    PL_KRN = 2'd1,
    PL_HYP = 2'd2
  } pl_e;

  // cause code equals the vector slot, except SENS which vectors through slot 1
  typedef enum logic [2:0] {
    CS_RST  = 3'd0,
    CS_UND  = 3'd1,
    CS_SVC  = 3'd2,
    CS_PABT = 3'd3,
    CS_DABT = 3'd4,
    CS_SENS = 3'd5,
    CS_IRQ  = 3'd6,
    CS_FIQ  = 3'd7
  } cause_e;

  // priority position -> cause, position 0 wins
  function automatic cause_e prio2cause(input logic [SRC_W-1:0] idx);
    case (idx)
      3'd0:    prio2cause = CS_RST;
      3'd1:    prio2cause = CS_DABT;
      3'd2:    prio2cause = CS_FIQ;
      3'd3:    prio2cause = CS_IRQ;
      3'd4:    prio2cause = CS_PABT;
      3'd5:    prio2cause = CS_SENS;
      3'd6:    prio2cause = CS_UND;
      default: prio2cause = CS_SVC;
    endcase
  endfunction

  // in guest mode, positions routed to the hypervisor: RST, FIQ, IRQ, SENS
  localparam logic [NUM_SRC-1:0] GUEST_HYP_MASK = 8'b0010_1101;

endpackage

// File: rtl/evt_req_build.sv
module evt_req_build
  import exc_vec_pkg::*;
#(
  parameter int N = NUM_SRC,
  parameter logic [N-1:0] HYP_MASK = GUEST_HYP_MASK
) (
  input  logic         ev_reset_i,
  input  logic         ev_undef_i,
  input  logic         ev_svc_i,
  input  logic         ev_pabt_i,
  input  logic         ev_dabt_i,
  input  logic         ev_irq_i,
  input  logic         ev_fiq_i,
  input  logic         insn_valid_i,
  input  logic         insn_priv_i,
  input  logic         insn_sens_i,
  input  logic [1:0]   cur_pl_i,
  input  logic         guest_i,
  output logic [N-1:0] req_o,
  output logic [N-1:0] rt_hyp_o
);

  logic priv_trap;
  logic sens_trap;

  assign priv_trap = insn_valid_i & insn_priv_i & (cur_pl_i == PL_USR);
  assign sens_trap = insn_valid_i & insn_sens_i & guest_i;

  always_comb begin
    req_o    = '0;
    req_o[0] = ev_reset_i;
    req_o[1] = ev_dabt_i;
    req_o[2] = ev_fiq_i;
    req_o[3] = ev_irq_i;
    req_o[4] = ev_pabt_i;
    req_o[5] = sens_trap;
    req_o[6] = ev_undef_i | priv_trap;
    req_o[7] = ev_svc_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_route
    assign rt_hyp_o[g] = ~guest_i | HYP_MASK[g];
  end

endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/vec_target.sv
module vec_target
  import exc_vec_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  cause_e        cause_i,
  input  logic          to_hyp_i,
  input  logic          guest_i,
  input  logic [1:0]    cur_pl_i,
  input  logic          hi_vec_i,
  input  logic [AW-1:0] gst_vbar_i,
  input  logic [AW-1:0] hyp_vbar_i,
  output logic [AW-1:0] pc_o,
  output logic [1:0]    new_pl_o,
  output logic          new_guest_o
);

  logic [2:0]    slot;
  logic [AW-1:0] base;

  assign slot = (cause_i == CS_SENS) ? 3'(CS_UND) : 3'(cause_i);
  assign base = hi_vec_i ? HI_BASE : (to_hyp_i ? hyp_vbar_i : gst_vbar_i);
  assign pc_o = base + AW'({slot, 2'b00});

  always_comb begin
    new_guest_o = ~to_hyp_i;
    if (cause_i == CS_RST) begin
      new_pl_o    = PL_HYP;
      new_guest_o = 1'b0;
    end else if (!to_hyp_i) begin
      new_pl_o = PL_KRN;
    end else if (guest_i) begin
      new_pl_o = PL_HYP;
    end else begin
      // host: never drop level, always leave user
      new_pl_o = (cur_pl_i == PL_HYP) ? PL_HYP : PL_KRN;
    end
  end

endmodule

// File: rtl/exc_vec_router.sv
module exc_vec_router
  import exc_vec_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ev_reset_i,
  input  logic          ev_undef_i,
  input  logic          ev_svc_i,
  input  logic          ev_pabt_i,
  input  logic          ev_dabt_i,
  input  logic          ev_irq_i,
  input  logic          ev_fiq_i,
  input  logic          insn_valid_i,
  input  logic          insn_priv_i,
  input  logic          insn_sens_i,
  input  logic [1:0]    cur_pl_i,
  input  logic          guest_i,
  input  logic          hi_vec_i,
  input  logic [AW-1:0] gst_vbar_i,
  input  logic [AW-1:0] hyp_vbar_i,
  output logic          take_o,
  output logic [AW-1:0] tgt_pc_o,
  output logic [1:0]    new_pl_o,
  output logic          new_guest_o,
  output logic [2:0]    cause_o,
  output logic          to_hyp_o
);

  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] rt_hyp;
  logic               any_req;
  logic [SRC_W-1:0]   win_idx;
  cause_e             win_cause;
  logic               win_hyp;
  logic [AW-1:0]      nxt_pc;
  logic [1:0]         nxt_pl;
  logic               nxt_guest;

  evt_req_build #(.N(NUM_SRC), .HYP_MASK(GUEST_HYP_MASK)) u_req (
    .ev_reset_i  (ev_reset_i),
    .ev_undef_i  (ev_undef_i),
    .ev_svc_i    (ev_svc_i),
    .ev_pabt_i   (ev_pabt_i),
    .ev_dabt_i   (ev_dabt_i),
    .ev_irq_i    (ev_irq_i),
    .ev_fiq_i    (ev_fiq_i),
    .insn_valid_i(insn_valid_i),
    .insn_priv_i (insn_priv_i),
    .insn_sens_i (insn_sens_i),
    .cur_pl_i    (cur_pl_i),
    .guest_i     (guest_i),
    .req_o       (req),
    .rt_hyp_o    (rt_hyp)
  );

  prio_pick #(.N(NUM_SRC)) u_pick (
    .req_i(req),
    .any_o(any_req),
    .idx_o(win_idx)
  );

  assign win_cause = prio2cause(win_idx);
  assign win_hyp   = rt_hyp[win_idx];

  vec_target #(.AW(AW), .HI_BASE(HI_BASE)) u_tgt (
    .cause_i    (win_cause),
    .to_hyp_i   (win_hyp),
    .guest_i    (guest_i),
    .cur_pl_i   (cur_pl_i),
    .hi_vec_i   (hi_vec_i),
    .gst_vbar_i (gst_vbar_i),
    .hyp_vbar_i (hyp_vbar_i),
    .pc_o       (nxt_pc),
    .new_pl_o   (nxt_pl),
    .new_guest_o(nxt_guest)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o      <= 1'b0;
      tgt_pc_o    <= '0;
      new_pl_o    <= PL_HYP;
      new_guest_o <= 1'b0;
      cause_o     <= CS_RST;
      to_hyp_o    <= 1'b0;
    end else begin
      take_o <= any_req;
      if (any_req) begin
        tgt_pc_o    <= nxt_pc;
        new_pl_o    <= nxt_pl;
        new_guest_o <= nxt_guest;
        cause_o     <= win_cause;
        to_hyp_o    <= win_hyp;
      end
    end
  end

endmodule

// File: rtl/exc_vec_router_chk.sv
module exc_vec_router_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ev_reset_i,
  input logic       ev_pabt_i,
  input logic       ev_dabt_i,
  input logic       insn_valid_i,
  input logic       insn_sens_i,
  input logic       guest_i,
  input logic       take_o,
  input logic [1:0] new_pl_o,
  input logic       new_guest_o,
  input logic [2:0] cause_o,
  input logic       to_hyp_o
);

  AST_RST_EVT_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ev_reset_i) |-> take_o); // R2

  AST_SYN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> ($stable(cause_o) && $stable(to_hyp_o))); // R13

  AST_HOST_TO_HYP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(!guest_i)) |-> to_hyp_o); // R7

  AST_HYP_LEAVES_GUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && to_hyp_o) |-> !new_guest_o); // R10

  AST_GUEST_ROUTE_KRN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !to_hyp_o) |-> (new_guest_o && new_pl_o == 2'd1)); // R9

  AST_RST_TOP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cause_o == 3'd0) |-> (to_hyp_o && new_pl_o == 2'd2 && !new_guest_o)); // R12

  AST_SENS_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(guest_i && insn_valid_i && insn_sens_i && !ev_dabt_i && !ev_pabt_i)
      |-> (take_o && to_hyp_o)); // R8

endmodule

bind exc_vec_router exc_vec_router_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ev_reset_i  (ev_reset_i),
  .ev_pabt_i   (ev_pabt_i),
  .ev_dabt_i   (ev_dabt_i),
  .insn_valid_i(insn_valid_i),
  .insn_sens_i (insn_sens_i),
  .guest_i     (guest_i),
  .take_o      (take_o),
  .new_pl_o    (new_pl_o),
  .new_guest_o (new_guest_o),
  .cause_o     (cause_o),
  .to_hyp_o    (to_hyp_o)
);

// File: tb/sim_exc_vec_router.sv
`timescale 1ns/1ps
module sim_exc_vec_router;

  localparam logic [31:0] GV = 32'h8000_0000;
  localparam logic [31:0] HV = 32'h4000_1000;
  localparam logic [31:0] HB = 32'hFFFF_0000;

  // ev bits: [6] reset [5] dabt [4] fiq [3] irq [2] pabt [1] undef [0] svc
  typedef struct packed {
    logic [6:0]  ev;
    logic        iv, ip, is;
    logic [1:0]  pl;
    logic        g, hv;
    logic        tk;
    logic [31:0] pc;
    logic [1:0]  npl;
    logic        ng;
    logic [2:0]  cs;
    logic        th;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{7'b0000000, 1'b0,1'b0,1'b0, 2'd0, 1'b0,1'b0, 1'b0, 32'h0,       2'd0, 1'b0, 3'd0, 1'b0, 4'd2},  // R2 idle
    '{7'b0000001, 1'b0,1'b0,1'b0, 2'd0, 1'b0,1'b0, 1'b1, HV + 32'h08, 2'd1, 1'b0, 3'd2, 1'b1, 4'd7},  // R7 host svc
    '{7'b0001000, 1'b0,1'b0,1'b0, 2'd0, 1'b0,1'b1, 1'b1, HB + 32'h18, 2'd1, 1'b0, 3'd6, 1'b1, 4'd4},  // R4 high base
    '{7'b0010000, 1'b0,1'b0,1'b0, 2'd2, 1'b0,1'b0, 1'b1, HV + 32'h1C, 2'd2, 1'b0, 3'd7, 1'b1, 4'd7},  // R7 from hyp level
    '{7'b0000000, 1'b1,1'b0,1'b1, 2'd1, 1'b0,1'b0, 1'b0, 32'h0,       2'd0, 1'b0, 3'd0, 1'b0, 4'd7},  // R7 sens ignored
    '{7'b0000000, 1'b1,1'b1,1'b0, 2'd0, 1'b0,1'b0, 1'b1, HV + 32'h04, 2'd1, 1'b0, 3'd1, 1'b1, 4'd6},  // R6 user priv
    '{7'b0000000, 1'b1,1'b1,1'b0, 2'd1, 1'b0,1'b0, 1'b0, 32'h0,       2'd0, 1'b0, 3'd0, 1'b0, 4'd6},  // R6 kernel priv
    '{7'b0000001, 1'b0,1'b0,1'b0, 2'd0, 1'b1,1'b0, 1'b1, GV + 32'h08, 2'd1, 1'b1, 3'd2, 1'b0, 4'd9},  // R9
    '{7'b0001000, 1'b0,1'b0,1'b0, 2'd0, 1'b1,1'b0, 1'b1, HV + 32'h18, 2'd2, 1'b0, 3'd6, 1'b1, 4'd10}, // R10 irq
    '{7'b0010000, 1'b0,1'b0,1'b0, 2'd1, 1'b1,1'b1, 1'b1, HB + 32'h1C, 2'd2, 1'b0, 3'd7, 1'b1, 4'd10}, // R10 fiq
    '{7'b0000000, 1'b1,1'b0,1'b1, 2'd1, 1'b1,1'b0, 1'b1, HV + 32'h04, 2'd2, 1'b0, 3'd5, 1'b1, 4'd8},  // R8 kernel sens
    '{7'b0000000, 1'b1,1'b1,1'b1, 2'd0, 1'b1,1'b0, 1'b1, HV + 32'h04, 2'd2, 1'b0, 3'd5, 1'b1, 4'd8},  // R8 priv+sens
    '{7'b0000000, 1'b1,1'b1,1'b0, 2'd0, 1'b1,1'b0, 1'b1, GV + 32'h04, 2'd1, 1'b1, 3'd1, 1'b0, 4'd11}, // R11 priv
    '{7'b0100000, 1'b0,1'b0,1'b0, 2'd0, 1'b1,1'b0, 1'b1, GV + 32'h10, 2'd1, 1'b1, 3'd4, 1'b0, 4'd11}, // R11 dabt
    '{7'b0000100, 1'b0,1'b0,1'b0, 2'd0, 1'b1,1'b1, 1'b1, HB + 32'h0C, 2'd1, 1'b1, 3'd3, 1'b0, 4'd11}, // R11 pabt
    '{7'b1000000, 1'b0,1'b0,1'b0, 2'd0, 1'b1,1'b0, 1'b1, HV,          2'd2, 1'b0, 3'd0, 1'b1, 4'd12}, // R12
    '{7'b1111111, 1'b1,1'b1,1'b1, 2'd0, 1'b1,1'b0, 1'b1, HV,          2'd2, 1'b0, 3'd0, 1'b1, 4'd5},  // R5 reset top
    '{7'b0111111, 1'b0,1'b0,1'b0, 2'd0, 1'b1,1'b0, 1'b1, GV + 32'h10, 2'd1, 1'b1, 3'd4, 1'b0, 4'd5},  // R5 dabt
    '{7'b0011100, 1'b0,1'b0,1'b0, 2'd0, 1'b1,1'b0, 1'b1, HV + 32'h1C, 2'd2, 1'b0, 3'd7, 1'b1, 4'd5},  // R5 fiq
    '{7'b0001101, 1'b0,1'b0,1'b0, 2'd0, 1'b1,1'b0, 1'b1, HV + 32'h18, 2'd2, 1'b0, 3'd6, 1'b1, 4'd5},  // R5 irq
    '{7'b0000111, 1'b1,1'b0,1'b1, 2'd0, 1'b1,1'b0, 1'b1, GV + 32'h0C, 2'd1, 1'b1, 3'd3, 1'b0, 4'd5},  // R5 pabt over sens
    '{7'b0000011, 1'b0,1'b0,1'b0, 2'd1, 1'b1,1'b0, 1'b1, GV + 32'h04, 2'd1, 1'b1, 3'd1, 1'b0, 4'd5},  // R5 und over svc
    '{7'b0000001, 1'b1,1'b0,1'b1, 2'd1, 1'b1,1'b0, 1'b1, HV + 32'h04, 2'd2, 1'b0, 3'd5, 1'b1, 4'd5}   // R5 sens over svc
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  ev = '0;
  logic        iv = 1'b0, ip = 1'b0, is = 1'b0;
  logic [1:0]  pl = 2'd0;
  logic        g = 1'b0, hv = 1'b0;
  logic        take;
  logic [31:0] pc;
  logic [1:0]  npl;
  logic        ng;
  logic [2:0]  cs;
  logic        th;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  exc_vec_router u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ev_reset_i(ev[6]), .ev_dabt_i(ev[5]), .ev_fiq_i(ev[4]), .ev_irq_i(ev[3]),
    .ev_pabt_i(ev[2]), .ev_undef_i(ev[1]), .ev_svc_i(ev[0]),
    .insn_valid_i(iv), .insn_priv_i(ip), .insn_sens_i(is),
    .cur_pl_i(pl), .guest_i(g), .hi_vec_i(hv),
    .gst_vbar_i(GV), .hyp_vbar_i(HV),
    .take_o(take), .tgt_pc_o(pc), .new_pl_o(npl), .new_guest_o(ng),
    .cause_o(cs), .to_hyp_o(th)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    ev = v.ev; iv = v.iv; ip = v.ip; is = v.is; pl = v.pl; g = v.g; hv = v.hv;
  endtask

  task automatic idle();
    ev = '0; iv = 1'b0; ip = 1'b0; is = 1'b0;
  endtask

  function automatic logic [2:0] ev_slot(input int b);
    case (b)
      6: ev_slot = 3'd0;
      5: ev_slot = 3'd4;
      4: ev_slot = 3'd7;
      3: ev_slot = 3'd6;
      2: ev_slot = 3'd3;
      1: ev_slot = 3'd1;
      default: ev_slot = 3'd2;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "take", 32'(take), 32'd0);
    chk("R1", "cause", 32'(cs), 32'd0);
    chk("R1", "to_hyp", 32'(th), 32'd0);
    chk("R1", "new_pl", 32'(npl), 32'd2);
    chk("R1", "new_guest", 32'(ng), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      chk($sformatf("R%0d", TBL[i].rq), $sformatf("v%0d take", i), 32'(take), 32'(TBL[i].tk));
      if (TBL[i].tk) begin
        chk($sformatf("R%0d", TBL[i].rq), $sformatf("v%0d pc", i), pc, TBL[i].pc);
        chk($sformatf("R%0d", TBL[i].rq), $sformatf("v%0d new_pl", i), 32'(npl), 32'(TBL[i].npl));
        chk($sformatf("R%0d", TBL[i].rq), $sformatf("v%0d new_guest", i), 32'(ng), 32'(TBL[i].ng));
        chk($sformatf("R%0d", TBL[i].rq), $sformatf("v%0d cause", i), 32'(cs), 32'(TBL[i].cs));
        chk($sformatf("R%0d", TBL[i].rq), $sformatf("v%0d to_hyp", i), 32'(th), 32'(TBL[i].th));
      end
    end

    // R2 strobe lasts one cycle for one sampled event
    idle(); g = 1'b1; pl = 2'd0; hv = 1'b0;
    @(negedge clk);
    ev = 7'b0000001;
    @(negedge clk);
    idle();
    chk("R2", "strobe high", 32'(take), 32'd1);
    @(negedge clk);
    chk("R2", "strobe low", 32'(take), 32'd0);

    // R13 syndrome holds; guest svc left cause 2, to_hyp 0
    g = 1'b0; is = 1'b1; iv = 1'b1; pl = 2'd1;   // R7 host sens, no trap
    repeat (3) @(negedge clk);
    chk("R13", "cause hold", 32'(cs), 32'd2);
    chk("R13", "to_hyp hold", 32'(th), 32'd0);
    chk("R7", "sens no take", 32'(take), 32'd0);
    idle();

    // R3 slot sweep with high base, slot 5 never used
    g = 1'b0; pl = 2'd0; hv = 1'b1;
    for (int b = 0; b < 7; b++) begin
      ev = 7'(1 << b);
      @(negedge clk);
      chk("R3", $sformatf("slot ev%0d", b), pc, HB + 32'({ev_slot(b), 2'b00}));
      chk("R3", $sformatf("no 0x14 ev%0d", b), 32'(pc[4:0] == 5'h14), 32'd0);
    end
    idle();
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule